// File: doc/BRIEF.md
# Register-Mediated Word Memory Controller

This block holds a synchronous word memory that a client can reach only through two internal registers. One register holds the address and the other holds the data. The client raises a one-cycle request together with an operation select, an address and, for writes, a data word. The block then runs a fixed sequence of steps. First it latches the request into the registers. Next it decodes the latched address. Then it moves a word between the data register and the addressed cell.

A fetch ends with the cell's content in the data register, which the client reads on a dedicated output. A store writes the data register into the addressed cell. In both cases a one-cycle completion pulse marks the end of the sequence. While a sequence is running, the block shows that it is busy and drops any new request. The address decoder sees only the latched address register, so the client may change the request buses as soon as its request has been accepted.

Top module: `mem_fetch_store`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are low and `mdr_out` is zero.
- R2: A request with `op_store`=0 (fetch) places the word last stored at `addr` on `mdr_out`, and it is valid in the cycle `done` is high.
- R3: A request with `op_store`=1 (store) writes `wdata` into the cell at `addr`, so a later fetch of that address returns it.
- R4: A request is accepted at a clock edge where `req` is high and `busy` is low. `busy` is then high for exactly three cycles, and `done` is high in the fourth cycle after the accepting edge, with `busy` low.
- R5: `done` stays high for exactly one cycle per accepted request.
- R6: A request raised while `busy` is high is ignored: it writes no cell and does not change the timing or the result of the running access.
- R7: When no request is accepted, `mdr_out` holds its value, whatever `addr`, `wdata` and `op_store` do.
- R8: After a store, `mdr_out` shows the stored word.
- R9: Changing `addr` or `wdata` after the accepting edge does not affect the running access, because the decoder uses only the latched address.
- R10: All 2^ADDR_W cells are independent, including the lowest (0) and the highest (all ones) address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled when idle |
| op_store | input | 1 | 1 = store, 0 = fetch |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Word to store |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| mdr_out | output | DATA_W | Content of the data register |

## Verification
On every cycle the embedded properties check the following: the reset state, that an accepted request raises `busy`, that `done` lasts one cycle and never overlaps `busy`, that the address register stays frozen while busy, and that the data register does not move while the block is idle and receives no request. The directed scenarios are the only way to show that the data comes back correctly. They cover store-then-fetch at several addresses, including both ends of the address range, the four-cycle latency, a dropped request during busy that must not reach memory, and bus changes after acceptance that must not redirect the access.

// File: rtl/memfs_pkg.sv
package memfs_pkg;

    parameter int ADDR_W = 12;
    parameter int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_XFER   = 2'd2,
        ST_FINISH = 2'd3
    } fs_state_e;

    typedef enum logic {
        OP_FETCH = 1'b0,
        OP_STORE = 1'b1
    } fs_op_e;

    // Step strobes issued by the sequencer to the register file and memory
    typedef struct packed {
        logic load_mar;
        logic load_wdata;
        logic decode;
        logic write;
        logic read;
        logic capture;
    } fs_ctrl_t;

    function automatic logic state_busy(fs_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/mfs_seq.sv
module mfs_seq
    import memfs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     op_store,
    output fs_ctrl_t ctl,
    output logic     busy,
    output logic     done
);

    fs_state_e state_q;
    fs_op_e    op_q;
    logic      done_q;
    logic      accept;

    assign busy   = state_busy(state_q);
    assign accept = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_FETCH;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= fs_op_e'(op_store);
                    state_q <= ST_DECODE;
                end
                ST_DECODE: state_q <= ST_XFER;
                ST_XFER:   state_q <= ST_FINISH;
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl            = '0;
        ctl.load_mar   = accept;
        ctl.load_wdata = accept && op_store;
        ctl.decode     = (state_q == ST_DECODE);
        ctl.write      = (state_q == ST_XFER)   && (op_q == OP_STORE);
        ctl.read       = (state_q == ST_XFER)   && (op_q == OP_FETCH);
        ctl.capture    = (state_q == ST_FINISH) && (op_q == OP_FETCH);
    end

    assign done = done_q;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

endmodule

// File: rtl/mfs_regs.sv
module mfs_regs
    import memfs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  fs_ctrl_t      ctl,
    input  logic          busy,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] row,
    output logic [DW-1:0] mdr
);

    logic [AW-1:0] mar_q;
    logic [AW-1:0] row_q;
    logic [DW-1:0] mdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            row_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ctl.load_mar)   mar_q <= addr;
            if (ctl.decode)     row_q <= mar_q;
            if (ctl.load_wdata) mdr_q <= wdata;
            else if (ctl.capture) mdr_q <= rdata;
        end
    end

    assign row = row_q;
    assign mdr = mdr_q;

    AST_MAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mar_q)); // R9

endmodule

// File: rtl/mfs_ram.sv
module mfs_ram
    import memfs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] row,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] dout_q;

    always_ff @(posedge clk) begin
        if (we) cells[row] <= din;
        if (re) dout_q <= cells[row];
    end

    assign dout = dout_q;

endmodule

// File: rtl/mem_fetch_store.sv
module mem_fetch_store
    import memfs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          op_store,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] mdr_out
);

    fs_ctrl_t      ctl;
    logic [AW-1:0] row;
    logic [DW-1:0] mdr;
    logic [DW-1:0] rdata;

    mfs_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .op_store (op_store),
        .ctl      (ctl),
        .busy     (busy),
        .done     (done)
    );

    mfs_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .busy  (busy),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .row   (row),
        .mdr   (mdr)
    );

    mfs_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk  (clk),
        .we   (ctl.write),
        .re   (ctl.read),
        .row  (row),
        .din  (mdr),
        .dout (rdata)
    );

    assign mdr_out = mdr;

    AST_MDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req) |=> $stable(mdr_out)); // R7
    AST_RESET_MDR: assert property (@(posedge clk) rst |=> (mdr_out == '0)); // R1

endmodule

// File: tb/mem_fetch_store_test.sv
module mem_fetch_store_test;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          op_store = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          busy;
    logic          done;
    logic [DW-1:0] mdr_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mem_fetch_store #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .req(req), .op_store(op_store),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done), .mdr_out(mdr_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for done; returns latency in negedges and MDR
    task automatic access(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat, output logic [DW-1:0] m);
        @(negedge clk);
        req = 1'b1; op_store = st; addr = a; wdata = d;
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            req = 1'b0;
            if (k <= 3) check(busy == 1'b1, "R4 busy during sequence", busy, 1);
            if (done) begin lat = k; break; end
        end
        m = mdr_out;
        check(busy == 1'b0, "R4 busy low at done", busy, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0, "R1 busy in reset", busy, 0);
        check(done == 0, "R1 done in reset", done, 0);
        check(mdr_out == 0, "R1 mdr in reset", mdr_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && mdr_out == 0, "R1 after reset", mdr_out, 0);
    endtask

    task automatic t_store_fetch;
        int lat; logic [DW-1:0] m;
        access(1'b1, 12'h0A5, 16'h1234, lat, m);
        check(lat == 4, "R4 store latency", lat, 4);
        check(m == 16'h1234, "R8 mdr after store", m, 16'h1234);
        @(negedge clk);
        check(done == 0, "R5 done one cycle", done, 0);
        access(1'b1, 12'h3C0, 16'hBEEF, lat, m);
        access(1'b0, 12'h0A5, 16'h0000, lat, m);
        check(lat == 4, "R4 fetch latency", lat, 4);
        check(m == 16'h1234, "R2 R3 fetch 0A5", m, 16'h1234);
        access(1'b0, 12'h3C0, 16'hFFFF, lat, m);
        check(m == 16'hBEEF, "R2 R3 fetch 3C0", m, 16'hBEEF);
    endtask

    task automatic t_ignore_busy;
        int lat; logic [DW-1:0] m;
        access(1'b1, 12'h200, 16'h0F0F, lat, m);
        @(negedge clk);
        req = 1'b1; op_store = 1'b0; addr = 12'h200;
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req = 1'b1; op_store = 1'b1; addr = 12'h200; wdata = 16'hDEAD;
            end else begin
                req = 1'b0;
            end
            if (done) begin lat = k; break; end
        end
        req = 1'b0;
        check(lat == 4, "R6 latency unchanged", lat, 4);
        check(mdr_out == 16'h0F0F, "R6 result unchanged", mdr_out, 16'h0F0F);
        @(negedge clk);
        check(done == 0 && busy == 0, "R6 no second sequence", busy, 0);
        access(1'b0, 12'h200, 16'h0000, lat, m);
        check(m == 16'h0F0F, "R6 cell not written", m, 16'h0F0F);
    endtask

    task automatic t_hold;
        int lat; logic [DW-1:0] m;
        access(1'b0, 12'h3C0, 16'h0000, lat, m);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            addr = 12'(k * 77); wdata = 16'(k * 1111); op_store = k[0];
        end
        check(mdr_out == 16'hBEEF, "R7 mdr held while idle", mdr_out, 16'hBEEF);
    endtask

    task automatic t_bus_change;
        int lat; logic [DW-1:0] m;
        access(1'b1, 12'h124, 16'h7777, lat, m);
        @(negedge clk);
        req = 1'b1; op_store = 1'b1; addr = 12'h123; wdata = 16'h5A5A;
        @(negedge clk);
        req = 1'b0; addr = 12'h124; wdata = 16'h1111;
        repeat (4) @(negedge clk);
        access(1'b0, 12'h123, 16'h0000, lat, m);
        check(m == 16'h5A5A, "R9 store went to latched address", m, 16'h5A5A);
        access(1'b0, 12'h124, 16'h0000, lat, m);
        check(m == 16'h7777, "R9 neighbour untouched", m, 16'h7777);
    endtask

    task automatic t_range;
        int lat; logic [DW-1:0] m;
        access(1'b1, 12'h000, 16'hA001, lat, m);
        access(1'b1, 12'hFFF, 16'hCFFF, lat, m);
        access(1'b0, 12'h000, 16'h0000, lat, m);
        check(m == 16'hA001, "R10 lowest address", m, 16'hA001);
        access(1'b0, 12'hFFF, 16'h0000, lat, m);
        check(m == 16'hCFFF, "R10 highest address", m, 16'hCFFF);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_store_fetch();
        t_ignore_busy();
        t_hold();
        t_bus_change();
        t_range();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule